// File: doc/BRIEF.md
# Dual-Alignment Buffered PWM Channel

This block is one 8-bit pulse-width channel. A channel clock enable advances its counter. The counter runs in one of two modes. In edge mode it counts up from zero to the period value and wraps. In symmetric mode it climbs from zero to the period value and then falls back to zero. The output level follows a comparison between the counter and the active duty value. A polarity input chooses which level the output holds inside the duty window.

Writes to the period and duty registers made while the channel runs go into written-value registers. The active copies pick them up only when the counter returns to zero, when the counter is written, or while the channel is disabled. This keeps every period whole. Read ports always show the last value written. A counter read port shows the live count.

Top module: `pwm_dual_chan`

## Requirements
- R1: In edge mode (`center`=0) the counter advances 0,1,...,PER and then returns to 0, so one period lasts PER+1 channel ticks.
- R2: In symmetric mode (`center`=1, PER ≥ 1) the counter climbs 0..PER and then falls PER-1..1 before returning to 0, so one period lasts 2·PER channel ticks. The count never exceeds a non-zero active PER.
- R3: In edge mode, with an active duty value DTY below PER, the output equals `polarity` while the count is 0..DTY and equals its inverse for the rest of the period.
- R4: In symmetric mode, with DTY below PER, the output equals `polarity` while rising with count < DTY, or while falling with count ≤ DTY. Otherwise it equals the inverse of `polarity`.
- R5: With DTY ≥ PER and DTY ≠ 0xFF, the output holds at `polarity` for the whole period and never changes on a duty match.
- R6: With DTY = 0xFF, the output holds permanently at the inverse of `polarity`.
- R7: Period and duty writes made while enabled take effect only when the counter returns to 0. A write that lands on the same tick as that return applies to the new period.
- R8: `per_rd` and `dty_rd` show the most recently written value one cycle after the write, whether or not it is active yet.
- R9: A pulse on `cnt_wr` while enabled sets the count to 0, restarts a rising period and loads the written period and duty values at once.
- R10: While `enable` is 0, the count is held at 0 and the output sits at the inverse of `polarity`. Written values become active on the next cycle.
- R11: Reset leaves both registers at 0xFF, the count at 0 and the output at 0.
- R12: The counter changes only on cycles with `clk_en` = 1, unless `cnt_wr` or a disable forces it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Channel clock tick |
| enable | input | 1 | Channel run enable |
| polarity | input | 1 | Output level inside the duty window |
| center | input | 1 | 1 selects symmetric up/down counting |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 8 | Period write value |
| dty_wr | input | 1 | Duty write strobe |
| dty_wdata | input | 8 | Duty write value |
| cnt_wr | input | 1 | Counter write strobe (restart) |
| per_rd | output | 8 | Last written period |
| dty_rd | output | 8 | Last written duty |
| cnt_rd | output | 8 | Current count |
| pwm_out | output | 1 | PWM output |

## Verification
The sharp collision is a register write that arrives on the very tick the counter returns to zero. The write and the buffer load then fall in the same cycle, and the new value must govern the period that starts there. The bench waits until the count shows the period value and raises the duty strobe so that it is sampled on the wrapping edge. A counter write issued together with a channel tick is also covered. A behavioural model tracks the position inside the period and compares count, output and read-back on every clock. It therefore judges whether the new duty shows up exactly at the first count of the new period.

// File: rtl/pwm_dual_chan_pkg.sv
package pwm_dual_chan_pkg;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/pwm_dual_chan_step.sv
module pwm_dual_chan_step
    import pwm_dual_chan_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cnt,
    input  cnt_dir_e     dir,
    input  logic [W-1:0] per,
    input  logic         center,
    output logic [W-1:0] cnt_nx,
    output cnt_dir_e     dir_nx,
    output logic         wrap
);

    always_comb begin
        cnt_nx = cnt;
        dir_nx = dir;
        wrap   = 1'b0;
        if (!center) begin
            // edge mode: up count, wrap after reaching the period value
            if (cnt >= per) begin
                cnt_nx = '0;
                dir_nx = DIR_UP;
                wrap   = 1'b1;
            end else begin
                cnt_nx = cnt + 1'b1;
            end
        end else if (dir == DIR_UP) begin
            cnt_nx = cnt + 1'b1;
            if (cnt_nx >= per) begin
                dir_nx = DIR_DN;
            end
        end else begin
            if (cnt <= W'(1)) begin
                cnt_nx = '0;
                dir_nx = DIR_UP;
                wrap   = 1'b1;
            end else begin
                cnt_nx = cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_dual_chan_level.sv
module pwm_dual_chan_level
    import pwm_dual_chan_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cnt,
    input  cnt_dir_e     dir,
    input  logic [W-1:0] dty,
    input  logic         center,
    input  logic         polarity,
    input  logic         run,
    output logic         level
);

    localparam logic [W-1:0] ALL_ONES = '1;

    logic in_win;

    always_comb begin
        if (dty == ALL_ONES) begin
            in_win = 1'b0;
        end else if (center && dir == DIR_UP) begin
            in_win = (cnt < dty);
        end else begin
            in_win = (cnt <= dty);
        end
        if (!run) begin
            level = ~polarity;
        end else begin
            level = in_win ? polarity : ~polarity;
        end
    end

endmodule

// File: rtl/pwm_dual_chan.sv
module pwm_dual_chan
    import pwm_dual_chan_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic         enable,
    input  logic         polarity,
    input  logic         center,
    input  logic         per_wr,
    input  logic [W-1:0] per_wdata,
    input  logic         dty_wr,
    input  logic [W-1:0] dty_wdata,
    input  logic         cnt_wr,
    output logic [W-1:0] per_rd,
    output logic [W-1:0] dty_rd,
    output logic [W-1:0] cnt_rd,
    output logic         pwm_out
);

    localparam logic [W-1:0] RST_VAL = '1;

    typedef struct packed {
        logic [W-1:0] per_w;
        logic [W-1:0] dty_w;
        logic [W-1:0] per_a;
        logic [W-1:0] dty_a;
        logic [W-1:0] cnt;
        cnt_dir_e     dir;
    } chan_st_t;

    chan_st_t     q;
    chan_st_t     d;
    logic         out_q;
    logic         out_d;
    logic [W-1:0] stp_cnt;
    cnt_dir_e     stp_dir;
    logic         stp_wrap;

    pwm_dual_chan_step #(.W(W)) u_step (
        .cnt    (q.cnt),
        .dir    (q.dir),
        .per    (q.per_a),
        .center (center),
        .cnt_nx (stp_cnt),
        .dir_nx (stp_dir),
        .wrap   (stp_wrap)
    );

    always_comb begin
        d = q;
        if (per_wr) d.per_w = per_wdata;
        if (dty_wr) d.dty_w = dty_wdata;
        if (!enable || cnt_wr) begin
            d.cnt   = '0;
            d.dir   = DIR_UP;
            d.per_a = d.per_w;
            d.dty_a = d.dty_w;
        end else if (clk_en) begin
            d.cnt = stp_cnt;
            d.dir = stp_dir;
            if (stp_wrap) begin
                d.per_a = d.per_w;
                d.dty_a = d.dty_w;
            end
        end
    end

    pwm_dual_chan_level #(.W(W)) u_level (
        .cnt      (d.cnt),
        .dir      (d.dir),
        .dty      (d.dty_a),
        .center   (center),
        .polarity (polarity),
        .run      (enable),
        .level    (out_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.per_w <= RST_VAL;
            q.dty_w <= RST_VAL;
            q.per_a <= RST_VAL;
            q.dty_a <= RST_VAL;
            q.cnt   <= '0;
            q.dir   <= DIR_UP;
            out_q   <= 1'b0;
        end else begin
            q     <= d;
            out_q <= out_d;
        end
    end

    assign per_rd  = q.per_w;
    assign dty_rd  = q.dty_w;
    assign cnt_rd  = q.cnt;
    assign pwm_out = out_q;

endmodule

// File: rtl/pwm_dual_chan_chk.sv
module pwm_dual_chan_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clk_en,
    input logic         enable,
    input logic         polarity,
    input logic         center,
    input logic         dty_wr,
    input logic [W-1:0] dty_wdata,
    input logic         cnt_wr,
    input logic [W-1:0] dty_rd,
    input logic [W-1:0] cnt_rd,
    input logic         pwm_out,
    input logic [W-1:0] per_act,
    input logic [W-1:0] dty_act
);

    localparam logic [W-1:0] ONES = '1;

    assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_rd == '0) && (pwm_out == ~$past(polarity)));

    assert_cnt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !clk_en && !cnt_wr) |=> (cnt_rd == $past(cnt_rd)));

    assert_read_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dty_wr |=> (dty_rd == $past(dty_wdata)));

    assert_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && dty_act == ONES) |-> (pwm_out == ~$past(polarity)));

    assert_left_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !center && clk_en && !cnt_wr && cnt_rd >= per_act) |=> (cnt_rd == '0));

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (per_act != '0) |-> (cnt_rd <= per_act));

    assert_cnt_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cnt_wr) |=> (cnt_rd == '0));

endmodule

bind pwm_dual_chan pwm_dual_chan_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .enable    (enable),
    .polarity  (polarity),
    .center    (center),
    .dty_wr    (dty_wr),
    .dty_wdata (dty_wdata),
    .cnt_wr    (cnt_wr),
    .dty_rd    (dty_rd),
    .cnt_rd    (cnt_rd),
    .pwm_out   (pwm_out),
    .per_act   (q.per_a),
    .dty_act   (q.dty_a)
);

// File: tb/sim_pwm_dual_chan.sv
`timescale 1ns/1ps
module sim_pwm_dual_chan;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       enable = 1'b0;
    logic       polarity = 1'b0;
    logic       center = 1'b0;
    logic       per_wr = 1'b0;
    logic [7:0] per_wdata = '0;
    logic       dty_wr = 1'b0;
    logic [7:0] dty_wdata = '0;
    logic       cnt_wr = 1'b0;
    logic [7:0] per_rd;
    logic [7:0] dty_rd;
    logic [7:0] cnt_rd;
    logic       pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model: position inside the period
    int m_pos = 0, m_perw = 255, m_dtyw = 255, m_pera = 255, m_dtya = 255;
    int m_cnt = 0;
    bit m_out = 1'b0;
    bit m_live = 1'b0;

    always #2.5 clk = ~clk;

    pwm_dual_chan u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .enable(enable),
        .polarity(polarity), .center(center), .per_wr(per_wr),
        .per_wdata(per_wdata), .dty_wr(dty_wr), .dty_wdata(dty_wdata),
        .cnt_wr(cnt_wr), .per_rd(per_rd), .dty_rd(dty_rd),
        .cnt_rd(cnt_rd), .pwm_out(pwm_out)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_perw = 255; m_dtyw = 255; m_pera = 255; m_dtya = 255;
            m_cnt = 0; m_out = 1'b0; m_live = 1'b0;
        end else begin
            int len;
            bit win;
            if (per_wr) m_perw = per_wdata;
            if (dty_wr) m_dtyw = dty_wdata;
            if (!enable || cnt_wr) begin
                m_pos = 0; m_pera = m_perw; m_dtya = m_dtyw;
            end else if (clk_en) begin
                m_pos++;
                len = center ? 2 * m_pera : m_pera + 1;
                if (m_pos >= len) begin
                    m_pos = 0; m_pera = m_perw; m_dtya = m_dtyw;
                end
            end
            m_cnt = (center && m_pos > m_pera) ? 2 * m_pera - m_pos : m_pos;
            if (m_dtya == 255) win = 1'b0;
            else if (!center) win = (m_pos <= m_dtya);
            else if (m_pos < m_pera) win = (m_pos < m_dtya);
            else win = (m_cnt <= m_dtya);
            m_out = !enable ? !polarity : (win ? polarity : !polarity);
            m_live = 1'b1;
        end
    end

    function automatic string out_tag();
        if (!enable) return "R10";
        if (m_dtya == 255) return "R6";
        if (m_dtya >= m_pera) return "R5";
        return center ? "R4" : "R3";
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            check(center ? "R2 count" : "R1 count", cnt_rd, m_cnt);
            check(out_tag(), pwm_out, m_out);
            check("R8 per_rd", per_rd, m_perw);
            check("R8 dty_rd", dty_rd, m_dtyw);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_per(input int v);
        per_wdata = 8'(v); per_wr = 1'b1; tick(1); per_wr = 1'b0;
    endtask

    task automatic wr_dty(input int v);
        dty_wdata = 8'(v); dty_wr = 1'b1; tick(1); dty_wr = 1'b0;
    endtask

    task automatic setup(input bit ctr, input bit pol, input int per, input int dty);
        enable = 1'b0; center = ctr; polarity = pol;
        wr_per(per); wr_dty(dty); tick(1);
        enable = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(3);
        // R11: reset values
        check("R11 out", pwm_out, 0);
        check("R11 per", per_rd, 255);
        check("R11 dty", dty_rd, 255);
        check("R11 cnt", cnt_rd, 0);
        rst_n = 1'b1;
        clk_en = 1'b1;
        tick(2);
        // R1 R3: edge mode, both polarities
        setup(1'b0, 1'b1, 9, 3); tick(35);
        setup(1'b0, 1'b0, 9, 3); tick(25);
        // R2 R4: symmetric mode, both polarities
        setup(1'b1, 1'b1, 6, 2); tick(40);
        setup(1'b1, 1'b0, 6, 4); tick(30);
        // R5: duty above period, R6: all ones
        setup(1'b0, 1'b1, 9, 12); tick(25);
        setup(1'b1, 1'b0, 5, 5); tick(25);
        setup(1'b0, 1'b1, 9, 255); tick(25);
        check("R6 out", pwm_out, 0);
        // R7 R8: buffered write mid period, read-back at once
        setup(1'b0, 1'b1, 7, 2); tick(3);
        wr_dty(5);
        check("R8 dty_rd", dty_rd, 5);
        wr_per(4);
        check("R8 per_rd", per_rd, 4);
        tick(25);
        // R7: write landing on the wrapping tick
        wait (cnt_rd == 8'd4); #1;
        dty_wdata = 8'd1; dty_wr = 1'b1; tick(1); dty_wr = 1'b0;
        check("R7 cnt", cnt_rd, 0);
        check("R7 out", pwm_out, 1);
        tick(1);
        check("R7 out", pwm_out, 1);
        tick(1);
        check("R7 out", pwm_out, 0);
        tick(12);
        // R9: counter write together with a tick
        setup(1'b1, 1'b1, 8, 3); tick(6);
        wr_dty(6);
        cnt_wr = 1'b1; tick(1); cnt_wr = 1'b0;
        check("R9 cnt", cnt_rd, 0);
        tick(30);
        // R12: half-rate channel clock
        for (int i = 0; i < 40; i++) begin
            clk_en = i[0];
            tick(1);
        end
        clk_en = 1'b1;
        // R10: disable mid period, then write while disabled
        tick(3);
        enable = 1'b0; tick(2);
        check("R10 cnt", cnt_rd, 0);
        check("R10 out", pwm_out, 0);
        wr_per(3); wr_dty(1); tick(1);
        enable = 1'b1; tick(20);
        finish_run();
    end

endmodule